// File: doc/BRIEF.md
# Slewed Clock Switch Divider Controller

This block eases the frequency step seen by the system when its clock changes source. It passes the new clock through a short sequence of power-of-two divisors before the clock runs undivided. When switching to a faster clock the ramp starts at a divisor of 2^N and halves it each step until the divisor is 1. When switching to a slower clock the ramp runs the other way: the divisor goes 2, 4 and on up to 2^N, and then the slow clock is applied undivided. Each step is held for D+1 clock cycles. A postscaler further divides the result by M+1. The divided clock leaves the block as a one-cycle clock enable.

Software programs N, D, M and two direction enables in a pending configuration register. That register is guarded by a key sequence, and its contents take effect only when the oscillator-switch strobe fires. A wake from standby sleep can also start an upward ramp, which uses the settings already in effect. The ramp is controlled by a state machine with three states. `RMP_IDLE` means no ramp and a divisor of 1. `RMP_UP` means the divisor is falling. `RMP_DN` means the divisor is rising. The transitions are:
- start-up: `RMP_IDLE` to `RMP_UP`, on a permitted faster switch or on a sleep exit.
- start-down: `RMP_IDLE` to `RMP_DN`, on a permitted slower switch.
- step: the state stays the same and the exponent moves by one.
- finish: `RMP_UP` or `RMP_DN` to `RMP_IDLE`, after the last step.
- cancel: any state to `RMP_IDLE`, on a switch whose slewing is disabled.

The key sequence uses three lock states. `LK_LOCKED` moves to `LK_KEY1` on the first key. `LK_KEY1` moves to `LK_OPEN` on the second key. Any other write returns to `LK_LOCKED`.

Top module: `slew_clk_ctrl`

## Requirements
- R1: After reset, the readback word `rd_data` equals `rst_delay_sel` in bits [3:0] and is 0 elsewhere. After reset, `busy` is 0, `div_exp` is 0 and `clk_en` is 1 every cycle.
- R2: A write to address 0 (the configuration) is accepted only if the two writes immediately before it were a write of 0x13579BDF and then a write of 0x2468ACE0, both to address 1. Otherwise `rd_data` does not change.
- R3: The key sequence opens the lock for one write only. Any other write made while the lock is open closes it again, so a following configuration write is ignored.
- R4: The configuration fields in `rd_data` use these positions: D in [3:0], M in [7:4], N in [10:8], up-enable in [12], down-enable in [13] and busy in [16]. Other bits read as 0. A pending value changes neither the ramp nor the postscaler until `osc_switch` is pulsed.
- R5: An `osc_switch` pulse with `switch_up`=1 and an up-enable of 1 starts an upward ramp when N≠0. From the cycle after the pulse, `div_exp` steps N, N−1, …, 1, and each value lasts D+1 cycles. After the last step `div_exp` returns to 0.
- R6: An `osc_switch` pulse with `switch_up`=0 and a down-enable of 1 starts a downward ramp when N≠0. From the cycle after the pulse, `div_exp` steps 1, 2, …, N, and each value lasts D+1 cycles. After the last step `div_exp` returns to 0.
- R7: A switch whose direction enable is 0, or whose N is 0, starts no ramp. It cancels any ramp in progress, leaving `div_exp`=0 and `busy`=0.
- R8: A `sleep_exit` pulse without `osc_switch` starts an upward ramp. It uses the N, D and up-enable that are in effect, not the pending ones, and starts only if that up-enable is 1 and that N is not 0.
- R9: `busy` is 1 exactly while a ramp step is held and 0 once the divisor is back to 1.
- R10: `clk_en` pulses once every (M+1)·2^div_exp cycles. After any change of that divisor, the first pulse comes in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 1 | Write address: 0 is the configuration, 1 is the key port |
| wr_data | input | 32 | Write data |
| osc_switch | input | 1 | One-cycle strobe: a clock-source switch is taking place |
| sleep_exit | input | 1 | One-cycle strobe: wake from standby sleep |
| switch_up | input | 1 | Direction of the switch: 1 means to a faster clock |
| rst_delay_sel | input | 4 | Reset value of the step-length field D |
| rd_data | output | 32 | Pending configuration and busy flag |
| busy | output | 1 | Ramp in progress |
| div_exp | output | 3 | Current ramp divisor exponent |
| clk_en | output | 1 | One-cycle enable of the divided clock |

## Verification
The assertions assume that `osc_switch` and `sleep_exit` are single-cycle pulses. They also assume that no configuration write lands in the same cycle as `osc_switch`, and that `switch_up` is stable while the strobe is high. The bench drives every input on the falling edge and raises each strobe for exactly one cycle. It separates configuration writes from switch strobes by at least one cycle. Random trials draw N, D, M, both enables and the direction from a seeded `$urandom`, and wait for each ramp to finish before the next trial.

// File: rtl/slew_pkg.sv
package slew_pkg;
    localparam int DATA_W   = 32;
    localparam int STEP_W   = 3;
    localparam int DLY_W    = 4;
    localparam int POST_W   = 4;
    localparam int DIV_W    = POST_W + (1 << STEP_W);

    localparam logic [DATA_W-1:0] KEY_FIRST  = 32'h1357_9BDF;
    localparam logic [DATA_W-1:0] KEY_SECOND = 32'h2468_ACE0;

    localparam int POS_DLY  = 0;
    localparam int POS_POST = 4;
    localparam int POS_STEP = 8;
    localparam int POS_UP   = 12;
    localparam int POS_DN   = 13;
    localparam int POS_BUSY = 16;

    typedef struct packed {
        logic              dn_en;
        logic              up_en;
        logic [STEP_W-1:0] steps;
        logic [POST_W-1:0] post;
        logic [DLY_W-1:0]  delay;
    } slew_cfg_t;

    typedef enum logic [1:0] {LK_LOCKED, LK_KEY1, LK_OPEN} lock_st_t;
    typedef enum logic [1:0] {RMP_IDLE, RMP_UP, RMP_DN} ramp_st_t;
endpackage

// File: rtl/slew_cfg_regs.sv
module slew_cfg_regs
    import slew_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              osc_switch,
    input  logic [DLY_W-1:0]  rst_delay_sel,
    output slew_cfg_t         pend,
    output slew_cfg_t         act
);
    lock_st_t st_q, st_d;
    logic     cfg_we;

    always_comb begin
        st_d   = st_q;
        cfg_we = 1'b0;
        if (wr_en) begin
            if (wr_addr && wr_data == KEY_FIRST) begin
                st_d = LK_KEY1;
            end else begin
                unique case (st_q)
                    LK_KEY1: st_d = (wr_addr && wr_data == KEY_SECOND) ? LK_OPEN : LK_LOCKED;
                    LK_OPEN: begin
                        cfg_we = !wr_addr;
                        st_d   = LK_LOCKED;
                    end
                    default: st_d = LK_LOCKED;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= LK_LOCKED;
            pend       <= '0;
            pend.delay <= rst_delay_sel;
            act        <= '0;
            act.delay  <= rst_delay_sel;
        end else begin
            st_q <= st_d;
            if (cfg_we) begin
                pend.delay <= wr_data[POS_DLY  +: DLY_W];
                pend.post  <= wr_data[POS_POST +: POST_W];
                pend.steps <= wr_data[POS_STEP +: STEP_W];
                pend.up_en <= wr_data[POS_UP];
                pend.dn_en <= wr_data[POS_DN];
            end
            if (osc_switch) act <= pend;
        end
    end

    p_relock_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == LK_OPEN && wr_en) |=> st_q != LK_OPEN);
    p_locked_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != LK_OPEN) |=> $stable(pend));
    p_apply_on_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_switch |=> $stable(act));
endmodule

// File: rtl/slew_ramp.sv
module slew_ramp
    import slew_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_switch,
    input  logic              sleep_exit,
    input  logic              switch_up,
    input  slew_cfg_t         pend,
    input  slew_cfg_t         act,
    output logic              busy,
    output logic [STEP_W-1:0] div_exp
);
    ramp_st_t          st_q, st_d;
    logic [STEP_W-1:0] exp_q, exp_d, n_q, n_d;
    logic [DLY_W-1:0]  cnt_q, cnt_d, d_q, d_d;
    logic              go_sw, go_sleep;

    assign go_sw    = osc_switch && (pend.steps != '0) &&
                      (switch_up ? pend.up_en : pend.dn_en);
    assign go_sleep = !osc_switch && sleep_exit && act.up_en && (act.steps != '0);

    always_comb begin
        st_d  = st_q;
        exp_d = exp_q;
        cnt_d = cnt_q;
        n_d   = n_q;
        d_d   = d_q;
        if (go_sw) begin
            n_d   = pend.steps;
            d_d   = pend.delay;
            cnt_d = pend.delay;
            st_d  = switch_up ? RMP_UP : RMP_DN;
            exp_d = switch_up ? pend.steps : STEP_W'(1);
        end else if (osc_switch) begin
            st_d  = RMP_IDLE;
            exp_d = '0;
        end else if (go_sleep) begin
            n_d   = act.steps;
            d_d   = act.delay;
            cnt_d = act.delay;
            st_d  = RMP_UP;
            exp_d = act.steps;
        end else begin
            unique case (st_q)
                RMP_IDLE: exp_d = '0;
                RMP_UP: begin
                    if (cnt_q != '0) begin
                        cnt_d = cnt_q - DLY_W'(1);
                    end else if (exp_q == STEP_W'(1)) begin
                        st_d  = RMP_IDLE;
                        exp_d = '0;
                    end else begin
                        exp_d = exp_q - STEP_W'(1);
                        cnt_d = d_q;
                    end
                end
                RMP_DN: begin
                    if (cnt_q != '0) begin
                        cnt_d = cnt_q - DLY_W'(1);
                    end else if (exp_q == n_q) begin
                        st_d  = RMP_IDLE;
                        exp_d = '0;
                    end else begin
                        exp_d = exp_q + STEP_W'(1);
                        cnt_d = d_q;
                    end
                end
                default: begin
                    st_d  = RMP_IDLE;
                    exp_d = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= RMP_IDLE;
            exp_q <= '0;
            cnt_q <= '0;
            n_q   <= '0;
            d_q   <= '0;
        end else begin
            st_q  <= st_d;
            exp_q <= exp_d;
            cnt_q <= cnt_d;
            n_q   <= n_d;
            d_q   <= d_d;
        end
    end

    always_comb begin
        busy    = (st_q != RMP_IDLE);
        div_exp = exp_q;
    end

    p_idle_unity_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == RMP_IDLE) |-> exp_q == '0);
    p_busy_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (div_exp != '0 && div_exp <= n_q));
    p_up_descends_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == RMP_UP && $past(st_q == RMP_UP) && !$past(osc_switch || sleep_exit)
         && exp_q != $past(exp_q)) |-> exp_q == $past(exp_q) - STEP_W'(1));
    p_dn_ascends_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == RMP_DN && $past(st_q == RMP_DN) && !$past(osc_switch || sleep_exit)
         && exp_q != $past(exp_q)) |-> exp_q == $past(exp_q) + STEP_W'(1));
    p_step_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt_q != '0 && !osc_switch && !sleep_exit) |=> exp_q == $past(exp_q));
endmodule

// File: rtl/slew_postdiv.sv
module slew_postdiv
    import slew_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [POST_W-1:0] post,
    input  logic [STEP_W-1:0] div_exp,
    output logic              clk_en
);
    logic [DIV_W-1:0] div_now, div_q, cnt_q;
    logic             chg;

    always_comb begin
        div_now = (DIV_W'(post) + DIV_W'(1)) << div_exp;
        chg     = (div_now != div_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= DIV_W'(1);
            cnt_q <= '0;
        end else begin
            div_q <= div_now;
            if (chg)               cnt_q <= '0;
            else if (cnt_q == '0)  cnt_q <= div_now - DIV_W'(1);
            else                   cnt_q <= cnt_q - DIV_W'(1);
        end
    end

    assign clk_en = (cnt_q == '0);

    p_cnt_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < div_q);
    p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        chg |=> clk_en);
endmodule

// File: rtl/slew_clk_ctrl.sv
module slew_clk_ctrl
    import slew_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              osc_switch,
    input  logic              sleep_exit,
    input  logic              switch_up,
    input  logic [DLY_W-1:0]  rst_delay_sel,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic [STEP_W-1:0] div_exp,
    output logic              clk_en
);
    slew_cfg_t pend, act;

    slew_cfg_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .osc_switch(osc_switch),
        .rst_delay_sel(rst_delay_sel), .pend(pend), .act(act)
    );

    slew_ramp u_ramp (
        .clk(clk), .rst_n(rst_n), .osc_switch(osc_switch),
        .sleep_exit(sleep_exit), .switch_up(switch_up),
        .pend(pend), .act(act), .busy(busy), .div_exp(div_exp)
    );

    slew_postdiv u_post (
        .clk(clk), .rst_n(rst_n), .post(act.post),
        .div_exp(div_exp), .clk_en(clk_en)
    );

    always_comb begin
        rd_data                       = '0;
        rd_data[POS_DLY  +: DLY_W]    = pend.delay;
        rd_data[POS_POST +: POST_W]   = pend.post;
        rd_data[POS_STEP +: STEP_W]   = pend.steps;
        rd_data[POS_UP]               = pend.up_en;
        rd_data[POS_DN]               = pend.dn_en;
        rd_data[POS_BUSY]             = busy;
    end

    p_busy_readback_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[POS_BUSY] == (div_exp != '0));
endmodule

// File: tb/test_slew_clk_ctrl.sv
module test_slew_clk_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, wr_addr = 1'b0;
    logic [31:0] wr_data = '0;
    logic        osc_switch = 1'b0, sleep_exit = 1'b0, switch_up = 1'b0;
    logic [3:0]  rst_delay_sel = 4'd9;
    logic [31:0] rd_data;
    logic        busy, clk_en;
    logic [2:0]  div_exp;

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    logic [31:0] exp_rd;

    always #5 clk = ~clk;

    slew_clk_ctrl i_slew_clk_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .osc_switch(osc_switch), .sleep_exit(sleep_exit),
        .switch_up(switch_up), .rst_delay_sel(rst_delay_sel),
        .rd_data(rd_data), .busy(busy), .div_exp(div_exp), .clk_en(clk_en)
    );

    function automatic logic [31:0] pack(int n, int d, int m, bit u, bit dn);
        logic [31:0] v = '0;
        v[3:0] = d[3:0]; v[7:4] = m[3:0]; v[10:8] = n[2:0];
        v[12] = u; v[13] = dn;
        return v;
    endfunction

    function automatic int exp_at(int i, int n, int d, bit up);
        int s;
        if (i >= n * (d + 1)) return 0;
        s = i / (d + 1);
        return up ? n - s : s + 1;
    endfunction

    task automatic chk(string req, logic [31:0] act_v, logic [31:0] exp_v);
        n_chk++;
        if (act_v !== exp_v) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, act_v, exp_v);
        end
    endtask

    task automatic wr(bit a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic cfg(logic [31:0] v);
        wr(1'b1, 32'h1357_9BDF);
        wr(1'b1, 32'h2468_ACE0);
        wr(1'b0, v);
    endtask

    // pulse strobe; sample from cycle after the strobe edge
    task automatic run_ramp(string req, bit sw, bit up, int n, int d, bit go);
        @(negedge clk);
        if (sw) begin osc_switch = 1'b1; switch_up = up; end
        else sleep_exit = 1'b1;
        @(negedge clk);
        osc_switch = 1'b0; sleep_exit = 1'b0;
        for (int i = 0; i <= n * (d + 1) + 1; i++) begin
            int e;
            e = go ? exp_at(i, n, d, up) : 0;
            chk(req, 32'(div_exp), 32'(e));
            chk("R9", 32'(busy), 32'(e != 0));
            @(negedge clk);
        end
    endtask

    task automatic gap(int m);
        int k;
        k = 0;
        while (!clk_en && k < 40) begin @(negedge clk); k++; end
        @(negedge clk);
        k = 1;
        while (!clk_en && k < 40) begin @(negedge clk); k++; end
        chk("R10", 32'(k), 32'(m + 1));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", rd_data, 32'd9);
        chk("R1", 32'(busy), 0);
        chk("R1", 32'(div_exp), 0);
        chk("R1", 32'(clk_en), 1);
        @(negedge clk);
        chk("R1", 32'(clk_en), 1);
        exp_rd = 32'd9;

        // R2: write without keys ignored; wrong second key ignored
        wr(1'b0, pack(3, 2, 1, 1, 1));
        chk("R2", rd_data, exp_rd);
        wr(1'b1, 32'h1357_9BDF); wr(1'b1, 32'h1111_2222); wr(1'b0, pack(3, 2, 1, 1, 1));
        chk("R2", rd_data, exp_rd);
        wr(1'b1, 32'h2468_ACE0); wr(1'b0, pack(3, 2, 1, 1, 1));
        chk("R2", rd_data, exp_rd);

        // R4 accepted write visible, ramp unaffected until strobe
        cfg(pack(2, 15, 1, 1, 1));
        exp_rd = pack(2, 15, 1, 1, 1);
        chk("R4", rd_data, exp_rd);
        repeat (3) @(negedge clk);
        chk("R4", 32'(div_exp), 0);
        chk("R4", 32'(clk_en), 1);

        // R3: second write after unlock ignored; stray write relocks
        wr(1'b0, pack(1, 1, 1, 0, 0));
        chk("R3", rd_data, exp_rd);
        wr(1'b1, 32'h1357_9BDF); wr(1'b1, 32'h2468_ACE0); wr(1'b1, 32'h0);
        wr(1'b0, pack(1, 1, 1, 0, 0));
        chk("R3", rd_data, exp_rd);

        // R5 + R10: up ramp N=2 D=15 M=1, divisor 8 during first step
        @(negedge clk);
        osc_switch = 1'b1; switch_up = 1'b1;
        @(negedge clk);
        osc_switch = 1'b0;
        for (int i = 0; i < 10; i++) begin
            chk("R5", 32'(div_exp), 32'(exp_at(i, 2, 15, 1)));
            if (i == 1 || i == 9) chk("R10", 32'(clk_en), 1);
            if (i == 5) chk("R10", 32'(clk_en), 0);
            @(negedge clk);
        end
        repeat (40) @(negedge clk);
        chk("R9", 32'(busy), 0);
        gap(1);

        // R6 down ramp
        cfg(pack(3, 1, 0, 0, 1));
        run_ramp("R6", 1, 0, 3, 1, 1);
        // R7 gated direction
        cfg(pack(3, 1, 4, 0, 1));
        run_ramp("R7", 1, 1, 3, 1, 0);
        gap(4);
        cfg(pack(0, 2, 0, 1, 1));
        run_ramp("R7", 1, 1, 0, 2, 0);
        // R7 cancel in progress
        cfg(pack(4, 3, 0, 1, 0));
        @(negedge clk); osc_switch = 1'b1; switch_up = 1'b1;
        @(negedge clk); osc_switch = 1'b0;
        repeat (3) @(negedge clk);
        chk("R7", 32'(busy), 1);
        osc_switch = 1'b1; switch_up = 1'b0;
        @(negedge clk); osc_switch = 1'b0;
        chk("R7", 32'(busy), 0);
        chk("R7", 32'(div_exp), 0);

        // R8 sleep exit uses effective settings
        cfg(pack(3, 1, 0, 1, 0));
        @(negedge clk); osc_switch = 1'b1; switch_up = 1'b0;
        @(negedge clk); osc_switch = 1'b0;
        cfg(pack(1, 0, 0, 0, 0));
        run_ramp("R8", 0, 1, 3, 1, 1);
        @(negedge clk); osc_switch = 1'b1; switch_up = 1'b0;
        @(negedge clk); osc_switch = 1'b0;
        run_ramp("R8", 0, 1, 1, 0, 0);

        // random trials
        for (int t = 0; t < 24; t++) begin
            int n, d, m;
            bit u, dn, up, go;
            n = $urandom_range(0, 7); d = $urandom_range(0, 6); m = $urandom_range(0, 15);
            u = 1'($urandom); dn = 1'($urandom); up = 1'($urandom);
            go = (n != 0) && (up ? u : dn);
            cfg(pack(n, d, m, u, dn));
            chk("R4", rd_data, pack(n, d, m, u, dn));
            run_ramp(up ? "R5" : "R6", 1, up, n, d, go);
            gap(m);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule